// File: doc/BRIEF.md
# Tile Map Video Overlay Controller

This block walks a 32 by 32 grid of character tiles in step with the display's pixel counters. It fetches two bytes per tile from a 2 KB video memory: the tile number, and an attribute byte stored 0x400 above it. It then presents both bytes together to the character pixel stage further down the video path. Tiles are numbered row by row, starting at the top-left corner of the screen. The memory answers one cycle after it is addressed. The block uses the low bits of the horizontal counter as a per-tile phase, so it reads the tile number and the attribute in successive cycles.

A control byte written by the processor decides how the generated graphics are mixed with an external laserdisc picture. Two bits choose between showing the disc picture and blanking it, and one of them also steers the upper half of the colour lookup. The top nibble gives one palette-bank bit for each horizontal pixel position modulo 4. One more bit lets a vertical counter tap through to the sound output as a tone, or holds that output low.

Top module: `tmo_overlay_top`

## Requirements
- R1: In a cycle where the low three horizontal counter bits (tile phase) are 0, vram_addr equals {1'b0, v_count_hi, h_count[7:3]}, which is the tile-number location of the current tile.
- R2: In every other tile phase, vram_addr equals the same tile location plus 0x400 (bit 10 set), which is the attribute location.
- R3: At the clock edge that ends tile phase 2, tile_index and tile_attr take the two bytes read for the current tile. They hold at all other edges, so both bytes show from phase 3 until phase 2 of the next tile.
- R4: A pulse on ctrl_wr_en loads the control byte at the clock edge, and the outputs follow it in the next cycle. After reset the control byte is 0x00, so pal_a7, pal_a8, ld_suppress and audio_out are all 0.
- R5: audio_out equals control bit 1 AND vertical counter bit 3 (v_count_hi[0]). When bit 1 is 0, audio_out stays 0.
- R6: With control bit 3 set, pal_a7 is 1 and ld_suppress is 1, whatever the value of bit 2.
- R7: With control bit 2 set and bit 3 clear, pal_a7 is 0 and ld_suppress is 1.
- R8: With control bits 2 and 3 both clear, pal_a7 is 0 and ld_suppress is 0, so the disc picture shows.
- R9: pal_a8 equals control bit (4 + h_count[1:0]), so each of bits 4 to 7 serves one horizontal pixel position modulo 4.
- R10: During reset and just after it, tile_index and tile_attr read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| h_count | input | 8 | Horizontal pixel counter; bits 7:3 give the tile column, bits 2:0 the tile phase |
| v_count_hi | input | 5 | Vertical counter bits 7:3 (tile row); bit 0 here is counter bit 3 |
| vram_addr | output | 11 | Video memory read address |
| vram_rdata | input | 8 | Video memory data, valid one cycle after the address |
| ctrl_wr_en | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 7 | Control byte bits 7:1 (bit 0 has no function) |
| tile_index | output | 8 | Tile number for the current tile |
| tile_attr | output | 8 | Attribute byte for the current tile |
| pal_a7 | output | 1 | Colour lookup address bit 7 |
| pal_a8 | output | 1 | Colour lookup address bit 8 |
| ld_suppress | output | 1 | High to blank the laserdisc picture |
| audio_out | output | 1 | Gated vertical-counter tone |

## Verification
The bench runs a full frame with a memory whose contents are computed from the address, and it compares every tile's pair of bytes in every cycle. A fetch pipeline that latches one phase early or late would show the next tile's number, or a neighbour's attribute, next to the wrong tile. All 256 control bytes are applied in turn, and each is tested across all four pixel positions and both levels of the vertical tap. This exposes a priority slip between the two blanking bits, such as bit 2 still driving pal_a7 while bit 3 is set, and a palette bit shifted by one pixel position. It also exposes an audio output that leaks the tap while the enable bit is clear.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

   localparam int PAL_SEL_BITS = 2;
   localparam int PAL_PHASES   = 1 << PAL_SEL_BITS;

   typedef struct packed {
      logic [PAL_PHASES-1:0] pal_bank;
      logic                  blank_hi;
      logic                  blank_lo;
      logic                  tone_en;
   } ovl_ctrl_t;

endpackage

// File: rtl/tmo_addr_gen.sv
module tmo_addr_gen #(
   parameter int COL_BITS = 5,
   parameter int ROW_BITS = 5,
   parameter int PIX_BITS = 3
) (
   input  logic [COL_BITS+PIX_BITS-1:0] h_count,
   input  logic [ROW_BITS-1:0]          v_row,
   output logic [ROW_BITS+COL_BITS:0]   vram_addr
);

   localparam int H_W = COL_BITS + PIX_BITS;

   logic [COL_BITS-1:0] col;
   logic [PIX_BITS-1:0] phase;
   logic                attr_sel;

   assign col       = h_count[H_W-1:PIX_BITS];
   assign phase     = h_count[PIX_BITS-1:0];
   assign attr_sel  = (phase != '0);
   assign vram_addr = {attr_sel, v_row, col};

endmodule

// File: rtl/tmo_fetch_pipe.sv
module tmo_fetch_pipe #(
   parameter int DATA_W   = 8,
   parameter int PIX_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PIX_BITS-1:0] phase,
   input  logic [DATA_W-1:0]   vram_rdata,
   output logic [DATA_W-1:0]   tile_index,
   output logic [DATA_W-1:0]   tile_attr
);

   localparam logic [PIX_BITS-1:0] PH_IDX_BACK  = PIX_BITS'(1);
   localparam logic [PIX_BITS-1:0] PH_ATTR_BACK = PIX_BITS'(2);

   logic [DATA_W-1:0] idx_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_hold   <= '0;
         tile_index <= '0;
         tile_attr  <= '0;
      end else begin
         if (phase == PH_IDX_BACK) begin
            idx_hold <= vram_rdata;
         end
         if (phase == PH_ATTR_BACK) begin
            tile_index <= idx_hold;
            tile_attr  <= vram_rdata;
         end
      end
   end

endmodule

// File: rtl/tmo_mix.sv
module tmo_mix
   import tmo_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [7:1]              wdata,
   input  logic [PAL_SEL_BITS-1:0] hphase,
   input  logic                    v_tap,
   output logic                    pal_a7,
   output logic                    pal_a8,
   output logic                    ld_suppress,
   output logic                    audio_out
);

   ovl_ctrl_t            ctrl_q;
   logic [PAL_PHASES-1:0] bank_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q <= ovl_ctrl_t'(wdata);
      end
   end

   for (genvar g = 0; g < PAL_PHASES; g++) begin : g_bank
      assign bank_hit[g] = (hphase == PAL_SEL_BITS'(g)) & ctrl_q.pal_bank[g];
   end

   assign pal_a8      = |bank_hit;
   assign pal_a7      = ctrl_q.blank_hi;
   assign ld_suppress = ctrl_q.blank_hi | ctrl_q.blank_lo;
   assign audio_out   = ctrl_q.tone_en & v_tap;

endmodule

// File: rtl/tmo_overlay_top.sv
module tmo_overlay_top #(
   parameter int COL_BITS   = 5,
   parameter int ROW_BITS   = 5,
   parameter int PIX_BITS   = 3,
   parameter int DATA_W     = 8,
   parameter int AUDIO_VBIT = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [COL_BITS+PIX_BITS-1:0]  h_count,
   input  logic [ROW_BITS-1:0]           v_count_hi,
   output logic [ROW_BITS+COL_BITS:0]    vram_addr,
   input  logic [DATA_W-1:0]             vram_rdata,
   input  logic                          ctrl_wr_en,
   input  logic [7:1]                    ctrl_wdata,
   output logic [DATA_W-1:0]             tile_index,
   output logic [DATA_W-1:0]             tile_attr,
   output logic                          pal_a7,
   output logic                          pal_a8,
   output logic                          ld_suppress,
   output logic                          audio_out
);

   localparam int SEL_BITS = tmo_pkg::PAL_SEL_BITS;
   localparam int TAP_IDX  = AUDIO_VBIT - PIX_BITS;

   if (PIX_BITS < SEL_BITS) begin : g_chk_pix
      $error("tmo_overlay_top: PIX_BITS must cover the palette phase bits");
   end
   if (PIX_BITS < 2) begin : g_chk_phase
      $error("tmo_overlay_top: at least four phases per tile are needed");
   end
   if (TAP_IDX < 0 || TAP_IDX >= ROW_BITS) begin : g_chk_tap
      $error("tmo_overlay_top: AUDIO_VBIT outside the tile-row counter bits");
   end
   if (COL_BITS < 1 || ROW_BITS < 1 || DATA_W < 1) begin : g_chk_dims
      $error("tmo_overlay_top: grid and data widths must be positive");
   end

   tmo_addr_gen #(
      .COL_BITS (COL_BITS),
      .ROW_BITS (ROW_BITS),
      .PIX_BITS (PIX_BITS)
   ) i_addr_gen (
      .h_count   (h_count),
      .v_row     (v_count_hi),
      .vram_addr (vram_addr)
   );

   tmo_fetch_pipe #(
      .DATA_W   (DATA_W),
      .PIX_BITS (PIX_BITS)
   ) i_fetch_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (h_count[PIX_BITS-1:0]),
      .vram_rdata (vram_rdata),
      .tile_index (tile_index),
      .tile_attr  (tile_attr)
   );

   tmo_mix i_mix (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (ctrl_wr_en),
      .wdata       (ctrl_wdata),
      .hphase      (h_count[SEL_BITS-1:0]),
      .v_tap       (v_count_hi[TAP_IDX]),
      .pal_a7      (pal_a7),
      .pal_a8      (pal_a8),
      .ld_suppress (ld_suppress),
      .audio_out   (audio_out)
   );

endmodule

// File: rtl/tmo_overlay_chk.sv
module tmo_overlay_chk #(
   parameter int COL_BITS   = 5,
   parameter int ROW_BITS   = 5,
   parameter int PIX_BITS   = 3,
   parameter int DATA_W     = 8,
   parameter int AUDIO_VBIT = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [COL_BITS+PIX_BITS-1:0] h_count,
   input logic [ROW_BITS-1:0]          v_count_hi,
   input logic [ROW_BITS+COL_BITS:0]   vram_addr,
   input logic                         ctrl_wr_en,
   input logic [7:1]                   ctrl_wdata,
   input logic [DATA_W-1:0]            tile_index,
   input logic [DATA_W-1:0]            tile_attr,
   input logic                         pal_a7,
   input logic                         pal_a8,
   input logic                         ld_suppress,
   input logic                         audio_out
);

   localparam int H_W     = COL_BITS + PIX_BITS;
   localparam int TAP_IDX = AUDIO_VBIT - PIX_BITS;

   logic [PIX_BITS-1:0] ph;
   logic [COL_BITS-1:0] col;
   assign ph  = h_count[PIX_BITS-1:0];
   assign col = h_count[H_W-1:PIX_BITS];

   AST_IDX_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == '0) |-> (vram_addr == {1'b0, v_count_hi, col}));   // R1
   AST_ATTR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != '0) |-> (vram_addr == {1'b1, v_count_hi, col}));   // R2
   AST_TILE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(tile_index) || !$stable(tile_attr)) |-> ($past(ph) == PIX_BITS'(2)));   // R3
   AST_TONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_en && !ctrl_wdata[1]) |=> !audio_out);   // R5
   AST_TONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
      audio_out |-> v_count_hi[TAP_IDX]);   // R5
   AST_FORCE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_en && ctrl_wdata[3]) |=> (pal_a7 && ld_suppress));   // R6
   AST_SOFT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_en && ctrl_wdata[2] && !ctrl_wdata[3]) |=> (!pal_a7 && ld_suppress));   // R7
   AST_SHOW_DISC: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_en && ctrl_wdata[3:2] == 2'b00) |=> (!pal_a7 && !ld_suppress));   // R8
   AST_A7_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      pal_a7 |-> ld_suppress);   // R6
   AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_en && ctrl_wdata[7:4] == 4'h0) |=> !pal_a8);   // R9

endmodule

bind tmo_overlay_top tmo_overlay_chk #(
   .COL_BITS   (COL_BITS),
   .ROW_BITS   (ROW_BITS),
   .PIX_BITS   (PIX_BITS),
   .DATA_W     (DATA_W),
   .AUDIO_VBIT (AUDIO_VBIT)
) i_tmo_overlay_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .h_count     (h_count),
   .v_count_hi  (v_count_hi),
   .vram_addr   (vram_addr),
   .ctrl_wr_en  (ctrl_wr_en),
   .ctrl_wdata  (ctrl_wdata),
   .tile_index  (tile_index),
   .tile_attr   (tile_attr),
   .pal_a7      (pal_a7),
   .pal_a8      (pal_a8),
   .ld_suppress (ld_suppress),
   .audio_out   (audio_out)
);

// File: tb/test_tmo_overlay_top.sv
module test_tmo_overlay_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  h_count = '0;
   logic [4:0]  v_count_hi = '0;
   logic [10:0] vram_addr;
   logic [7:0]  vram_rdata = '0;
   logic        ctrl_wr_en = 1'b0;
   logic [7:1]  ctrl_wdata = '0;
   logic [7:0]  tile_index;
   logic [7:0]  tile_attr;
   logic        pal_a7;
   logic        pal_a8;
   logic        ld_suppress;
   logic        audio_out;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmo_overlay_top i_tmo_overlay_top (
      .clk         (clk),
      .rst_n       (rst_n),
      .h_count     (h_count),
      .v_count_hi  (v_count_hi),
      .vram_addr   (vram_addr),
      .vram_rdata  (vram_rdata),
      .ctrl_wr_en  (ctrl_wr_en),
      .ctrl_wdata  (ctrl_wdata),
      .tile_index  (tile_index),
      .tile_attr   (tile_attr),
      .pal_a7      (pal_a7),
      .pal_a8      (pal_a8),
      .ld_suppress (ld_suppress),
      .audio_out   (audio_out)
   );

   function automatic logic [7:0] mem_val(input logic [10:0] a);
      int unsigned v;
      v = int'(a) * 29 + (int'(a) >> 3) + 11;
      return v[7:0];
   endfunction

   always @(posedge clk) vram_rdata <= mem_val(vram_addr);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h h=%0d v=%0d", tag, act, exp, h_count, v_count_hi);
      end
   endtask

   task automatic write_ctrl(input logic [7:0] val);
      @(negedge clk);
      ctrl_wr_en = 1'b1;
      ctrl_wdata = val[7:1];
      @(negedge clk);
      ctrl_wr_en = 1'b0;
      ctrl_wdata = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] e_idx;
      logic [7:0] e_attr;
      logic       have_tile;
      logic [7:0] fc;

      v_count_hi = 5'd1;
      repeat (3) @(negedge clk);
      #1;
      chk("R10 idx in reset", 32'(tile_index), 0);
      chk("R10 attr in reset", 32'(tile_attr), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R10 idx after reset", 32'(tile_index), 0);
      chk("R4 reset suppress", 32'(ld_suppress), 0);
      chk("R4 reset a7", 32'(pal_a7), 0);
      chk("R4 reset audio", 32'(audio_out), 0);
      for (int p = 0; p < 4; p++) begin
         h_count = 8'(p);
         #1;
         chk("R4 reset a8", 32'(pal_a8), 0);
      end

      for (int c = 0; c < 256; c++) begin
         logic [7:0] cv;
         cv = 8'(c);
         write_ctrl(cv);
         for (int p = 0; p < 4; p++) begin
            for (int vb = 0; vb < 2; vb++) begin
               h_count    = 8'(p);
               v_count_hi = 5'(vb);
               #1;
               chk("R4 R6 R7 R8 a7", 32'(pal_a7), 32'(cv[3]));
               if (cv[3])
                  chk("R6 forced blank", 32'(ld_suppress), 1);
               else if (cv[2])
                  chk("R7 soft blank", 32'(ld_suppress), 1);
               else
                  chk("R8 disc shows", 32'(ld_suppress), 0);
               chk("R9 palette bank", 32'(pal_a8), 32'(cv[4+p]));
               chk("R5 tone gate", 32'(audio_out), 32'(cv[1] & vb[0]));
            end
         end
      end

      fc = 8'hA6;
      write_ctrl(fc);
      have_tile = 1'b0;
      e_idx = '0;
      e_attr = '0;
      for (int k = 0; k < 65536 + 16; k++) begin
         logic [7:0]  hv;
         logic [7:0]  vv;
         logic [10:0] base;
         @(negedge clk);
         hv = 8'(k % 256);
         vv = 8'((k / 256) % 256);
         h_count    = hv;
         v_count_hi = vv[7:3];
         base = {1'b0, vv[7:3], hv[7:3]};
         #1;
         if (hv[2:0] == 3'd0)
            chk("R1 index addr", 32'(vram_addr), 32'(base));
         else
            chk("R2 attr addr", 32'(vram_addr), 32'(base) + 32'h400);
         if (hv[2:0] == 3'd3) begin
            e_idx = mem_val(base);
            e_attr = mem_val(base + 11'h400);
            have_tile = 1'b1;
         end
         if (have_tile) begin
            chk("R3 tile index", 32'(tile_index), 32'(e_idx));
            chk("R3 tile attr", 32'(tile_attr), 32'(e_attr));
         end
         chk("R9 frame bank", 32'(pal_a8), 32'(fc[4 + int'(hv[1:0])]));
         chk("R5 frame tone", 32'(audio_out), 32'(vv[3]));
         chk("R7 frame blank", 32'({pal_a7, ld_suppress}), 32'b01);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule